// File: doc/BRIEF.md
# Sv32 Leaf Entry Access Guard

This block rules on one memory access against a 32-bit Sv32 leaf page-table entry that a walker or TLB has already produced. Each request carries the entry word, the kind of access (load, store or instruction fetch), the current privilege (user or supervisor), the supervisor-may-touch-user-pages control, the switch that lets hardware maintain the accessed and dirty flags, and the tree level where the leaf was found.

One clock after a request strobe, the block reports either a grant or a page fault, along with a code that names the first failing rule. For a granted access whose accessed flag, or dirty flag on a store, still needs setting, it also raises an update request and gives the flag values to write back. When hardware flag upkeep is off, the same situation becomes a fault that software handles.

The block holds no state apart from the registered result. The translated address, the walk itself and the physical-memory checks belong to neighbouring logic.

Top module: `sv32_leaf_guard`

## Requirements
- R1: The entry layout is V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, G bit 5, A bit 6, D bit 7, software bits 9:8, low page number 19:10, high page number 31:20. `acc_i` is 0 for load, 1 for store and 2 for fetch. A request sampled at a rising edge produces `rsp_vld_o`=1 and its result after that same edge. With no request, `rsp_vld_o`=0 and all other outputs are 0.
- R2: V=0 always gives a fault with cause 1, whatever the other 31 bits hold.
- R3: W=1 together with R=0 is a reserved encoding and gives a fault with cause 2.
- R4: In user mode (`umode_i`=1), an entry with U=0 gives a fault with cause 3.
- R5: In supervisor mode, a load or store to an entry with U=1 gives a fault with cause 3 unless `sum_i`=1. A fetch from an entry with U=1 gives a fault with cause 3 whatever `sum_i` is.
- R6: A load needs R=1, a store needs W=1 and a fetch needs X=1. A missing right, or `acc_i`=3, gives a fault with cause 4.
- R7: With `lvl_i`=1, a nonzero low page number (bits 19:10) gives a fault with cause 5. With `lvl_i`=0, those bits have no effect.
- R8: With `hwad_i`=0, an access with A=0, or a store with D=0, gives a fault with cause 6 and no update request.
- R9: With `hwad_i`=1, such an access is granted with `upd_req_o`=1 and `upd_a_o`=1. `upd_d_o` is 1 for a store and the entry's current D otherwise. An access whose flags are already set raises no update.
- R10: When several rules fail, the reported cause is the lowest-numbered one, in the order 1 to 6. A grant reports cause 0, with `allow_o`=1 and `fault_o`=0.
- R11: The G bit and the software bits 9:8 do not change any output.
- R12: While reset is asserted and after it, before the first request, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one per check |
| pte_i | input | 32 | Leaf entry word |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| umode_i | input | 1 | 1 = user privilege, 0 = supervisor |
| sum_i | input | 1 | Supervisor access to user pages permitted |
| hwad_i | input | 1 | Hardware maintains accessed/dirty flags |
| lvl_i | input | 1 | Level of the leaf: 1 = megapage, 0 = base page |
| rsp_vld_o | output | 1 | Result valid, one cycle after the request |
| allow_o | output | 1 | Access granted |
| fault_o | output | 1 | Page fault |
| cause_o | output | 3 | First failing rule, 0 when granted |
| upd_req_o | output | 1 | Request to write back the flags |
| upd_a_o | output | 1 | Accessed value to write |
| upd_d_o | output | 1 | Dirty value to write |

## Verification
On every cycle, the assertions check the one-cycle response timing, that grant and fault are exclusive, that an invalid entry always faults with its code, that a supervisor fetch from a user page never succeeds, and that an update is raised only on a grant and never while hardware upkeep is off. The bench's scenarios are what show the fault priority between overlapping violations, the exact cause codes for each rule, the dirty value written back on loads versus stores, and that the global and software bits, or a base-page leaf's low page number, leave the result unchanged.

// File: rtl/sv32_guard_pkg.sv
package sv32_guard_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CZ_NONE    = 3'd0,
    CZ_INVALID = 3'd1,
    CZ_RSVENC  = 3'd2,
    CZ_PRIV    = 3'd3,
    CZ_PERM    = 3'd4,
    CZ_ALIGN   = 3'd5,
    CZ_ADFLAG  = 3'd6
  } cause_e;

  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } pte_flags_t;

  // access kind is backed by the matching right in the entry
  function automatic logic f_right_ok(input acc_e acc, input pte_flags_t fl);
    logic ok;
    case (acc)
      ACC_LOAD:  ok = fl.r;
      ACC_STORE: ok = fl.w;
      ACC_FETCH: ok = fl.x;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  // accessed or dirty flag is still clear for this access
  function automatic logic f_flag_stale(input acc_e acc, input pte_flags_t fl);
    return !fl.a || ((acc == ACC_STORE) && !fl.d);
  endfunction

endpackage

// File: rtl/sv32_entry_split.sv
module sv32_entry_split
  import sv32_guard_pkg::*;
#(
  parameter int ENTRY_W  = 32,
  parameter int FLAG_W   = 8,
  parameter int LOPN_LSB = 10,
  parameter int LOPN_W   = 10
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output pte_flags_t         flags_o,
  output logic               lopn_nz_o
);
  localparam int LOPN_MSB = LOPN_LSB + LOPN_W - 1;

  assign flags_o   = pte_flags_t'(entry_i[FLAG_W-1:0]);
  assign lopn_nz_o = |entry_i[LOPN_MSB:LOPN_LSB];
endmodule

// File: rtl/sv32_priv_gate.sv
module sv32_priv_gate
  import sv32_guard_pkg::*;
(
  input  logic umode_i,
  input  logic sum_i,
  input  acc_e acc_i,
  input  logic upage_i,
  output logic priv_fault_o
);
  logic user_blocked;
  logic sup_blocked;

  assign user_blocked = umode_i && !upage_i;
  assign sup_blocked  = !umode_i && upage_i && ((acc_i == ACC_FETCH) || !sum_i);
  assign priv_fault_o = user_blocked || sup_blocked;
endmodule

// File: rtl/sv32_right_flags.sv
module sv32_right_flags
  import sv32_guard_pkg::*;
(
  input  acc_e       acc_i,
  input  pte_flags_t flags_i,
  input  logic       hwad_i,
  output logic       perm_fault_o,
  output logic       ad_fault_o,
  output logic       upd_need_o,
  output logic       upd_d_val_o
);
  logic stale;

  assign stale        = f_flag_stale(acc_i, flags_i);
  assign perm_fault_o = !f_right_ok(acc_i, flags_i);
  assign ad_fault_o   = stale && !hwad_i;
  assign upd_need_o   = stale && hwad_i;
  assign upd_d_val_o  = (acc_i == ACC_STORE) || flags_i.d;
endmodule

// File: rtl/sv32_leaf_guard.sv
module sv32_leaf_guard
  import sv32_guard_pkg::*;
#(
  parameter int ENTRY_W  = 32,
  parameter int LOPN_LSB = 10,
  parameter int LOPN_W   = 10,
  parameter int CAUSE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [ENTRY_W-1:0] pte_i,
  input  logic [1:0]         acc_i,
  input  logic               umode_i,
  input  logic               sum_i,
  input  logic               hwad_i,
  input  logic               lvl_i,
  output logic               rsp_vld_o,
  output logic               allow_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               upd_req_o,
  output logic               upd_a_o,
  output logic               upd_d_o
);
  localparam int FLAG_W = $bits(pte_flags_t);

  acc_e       acc;
  pte_flags_t flags;
  logic       lopn_nz;
  logic       ev_invalid, ev_rsvenc, ev_priv, ev_perm, ev_align, ev_adflag;
  logic       ev_upd_need, upd_d_val;
  cause_e     cause_nx;
  logic       grant_nx;

  assign acc = acc_e'(acc_i);

  sv32_entry_split #(
    .ENTRY_W (ENTRY_W),
    .FLAG_W  (FLAG_W),
    .LOPN_LSB(LOPN_LSB),
    .LOPN_W  (LOPN_W)
  ) u_split (
    .entry_i  (pte_i),
    .flags_o  (flags),
    .lopn_nz_o(lopn_nz)
  );

  sv32_priv_gate u_priv (
    .umode_i     (umode_i),
    .sum_i       (sum_i),
    .acc_i       (acc),
    .upage_i     (flags.u),
    .priv_fault_o(ev_priv)
  );

  sv32_right_flags u_rights (
    .acc_i       (acc),
    .flags_i     (flags),
    .hwad_i      (hwad_i),
    .perm_fault_o(ev_perm),
    .ad_fault_o  (ev_adflag),
    .upd_need_o  (ev_upd_need),
    .upd_d_val_o (upd_d_val)
  );

  assign ev_invalid = !flags.v;
  assign ev_rsvenc  = flags.w && !flags.r;
  assign ev_align   = lvl_i && lopn_nz;

  // fixed rule order, first failure wins
  always_comb begin
    if (ev_invalid)     cause_nx = CZ_INVALID;
    else if (ev_rsvenc) cause_nx = CZ_RSVENC;
    else if (ev_priv)   cause_nx = CZ_PRIV;
    else if (ev_perm)   cause_nx = CZ_PERM;
    else if (ev_align)  cause_nx = CZ_ALIGN;
    else if (ev_adflag) cause_nx = CZ_ADFLAG;
    else                cause_nx = CZ_NONE;
  end

  assign grant_nx = (cause_nx == CZ_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld_o <= 1'b0;
      allow_o   <= 1'b0;
      fault_o   <= 1'b0;
      cause_o   <= '0;
      upd_req_o <= 1'b0;
      upd_a_o   <= 1'b0;
      upd_d_o   <= 1'b0;
    end else begin
      rsp_vld_o <= req_i;
      allow_o   <= req_i && grant_nx;
      fault_o   <= req_i && !grant_nx;
      cause_o   <= req_i ? CAUSE_W'(cause_nx) : '0;
      upd_req_o <= req_i && grant_nx && ev_upd_need;
      upd_a_o   <= req_i && grant_nx && ev_upd_need;
      upd_d_o   <= req_i && grant_nx && ev_upd_need && upd_d_val;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rsp_vld_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !rsp_vld_o && !allow_o && !fault_o && !upd_req_o); // R1
  AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !pte_i[0]) |=> fault_o && (cause_o == CAUSE_W'(1))); // R2
  AST_SUP_FETCH_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !umode_i && (acc_i == 2'd2) && pte_i[4]) |=> !allow_o); // R5
  AST_GRANT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld_o |-> $onehot({allow_o, fault_o})); // R10
  AST_UPD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req_o |-> allow_o && upd_a_o); // R9
  AST_NO_UPD_SW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !hwad_i) |=> !upd_req_o); // R8
endmodule

// File: tb/test_sv32_leaf_guard.sv
module test_sv32_leaf_guard;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       allow;
    logic       fault;
    logic [2:0] cause;
    logic       upd;
    logic       ua;
    logic       ud;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] pte_i = '0;
  logic [1:0]  acc_i = '0;
  logic        umode_i = 1'b0, sum_i = 1'b0, hwad_i = 1'b0, lvl_i = 1'b0;
  logic        rsp_vld_o, allow_o, fault_o, upd_req_o, upd_a_o, upd_d_o;
  logic [2:0]  cause_o;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t sb[$];
  logic req_seen = 1'b0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sv32_leaf_guard i_sv32_leaf_guard (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .pte_i(pte_i), .acc_i(acc_i),
    .umode_i(umode_i), .sum_i(sum_i), .hwad_i(hwad_i), .lvl_i(lvl_i),
    .rsp_vld_o(rsp_vld_o), .allow_o(allow_o), .fault_o(fault_o), .cause_o(cause_o),
    .upd_req_o(upd_req_o), .upd_a_o(upd_a_o), .upd_d_o(upd_d_o)
  );

  // entry builder: flags byte is {D,A,G,U,X,W,R,V}
  function automatic logic [31:0] mk(input logic [11:0] hi, input logic [9:0] lo,
                                     input logic [1:0] sw, input logic [7:0] fl);
    return {hi, lo, sw, fl};
  endfunction

  // bench reference: list the rule failures, then take the lowest index
  function automatic exp_t model(input logic [31:0] e, input logic [1:0] k, input logic um,
                                 input logic sm, input logic hw, input logic lv, input string t);
    exp_t x;
    logic [6:1] bad;
    logic need;
    logic [2:0] c;
    need   = (e[6] == 1'b0) || (k == 2'd1 && e[7] == 1'b0);
    bad[1] = (e[0] == 1'b0);
    bad[2] = (e[2:1] == 2'b10);
    bad[3] = um ? (e[4] == 1'b0) : (e[4] == 1'b1 && (k == 2'd2 || sm == 1'b0));
    bad[4] = (k == 2'd3) || (k == 2'd0 && !e[1]) || (k == 2'd1 && !e[2]) || (k == 2'd2 && !e[3]);
    bad[5] = lv && (e[19:10] != 10'd0);
    bad[6] = need && !hw;
    c = 3'd0;
    for (int i = 6; i >= 1; i--) if (bad[i]) c = 3'(i);
    x.cause = c;
    x.allow = (c == 3'd0);
    x.fault = (c != 3'd0);
    x.upd   = x.allow && hw && need;
    x.ua    = x.upd;
    x.ud    = x.upd && (k == 2'd1 || e[7]);
    x.tag   = t;
    return x;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] e, input logic [1:0] k, input logic um,
                       input logic sm, input logic hw, input logic lv, input string t);
    @(negedge clk);
    pte_i = e; acc_i = k; umode_i = um; sum_i = sm; hwad_i = hw; lvl_i = lv; req_i = 1'b1;
    sb.push_back(model(e, k, um, sm, hw, lv, t));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_i = 1'b0;
      pte_i = 32'hFFFF_FFFF;
    end
  endtask

  always @(posedge clk) req_seen <= rst_n && req_i;

  // monitor: valid tracks the request, then results pop from the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 valid timing", {7'd0, rsp_vld_o}, {7'd0, req_seen});
      if (rsp_vld_o && sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        chk(x.tag, {allow_o, fault_o, upd_req_o, upd_a_o, upd_d_o, cause_o},
                   {x.allow, x.fault, x.upd, x.ua, x.ud, x.cause});
      end else if (!rsp_vld_o) begin
        chk("R1 idle outputs zero", {allow_o, fault_o, upd_req_o, upd_a_o, upd_d_o, cause_o}, 8'd0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {rsp_vld_o, allow_o, fault_o, upd_req_o, upd_a_o, cause_o},
        {5'd0, 3'd0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 post-reset outputs", {rsp_vld_o, allow_o, fault_o, upd_req_o, upd_a_o, cause_o},
        {5'd0, 3'd0});

    // R2 invalid
    drive(32'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 zero entry");
    drive(32'hFFFF_FFFE, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R2 all but V set");
    idle(1);
    // R3 reserved W without R
    drive(mk(12'h1, 10'h0, 2'd0, 8'b1100_1101), 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R3 W+X no R");
    // R4 user mode
    drive(mk(12'h2, 10'h3, 2'd0, 8'b1100_0111), 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 user on S page");
    drive(mk(12'h2, 10'h3, 2'd0, 8'b1101_0111), 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 user on U page");
    // R5 supervisor and user pages
    drive(mk(12'h3, 10'h0, 2'd0, 8'b1101_0011), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 S load U page no SUM");
    drive(mk(12'h3, 10'h0, 2'd0, 8'b1101_0011), 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 S load U page SUM");
    drive(mk(12'h3, 10'h0, 2'd0, 8'b1101_0111), 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 S store U page SUM");
    drive(mk(12'h3, 10'h0, 2'd0, 8'b1101_1011), 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R5 S fetch U page SUM");
    drive(mk(12'h3, 10'h0, 2'd0, 8'b1100_1011), 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R5 S fetch S page");
    idle(2);
    // R6 rights
    drive(mk(12'h4, 10'h0, 2'd0, 8'b1100_1001), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 load no R");
    drive(mk(12'h4, 10'h0, 2'd0, 8'b1100_0011), 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 store no W");
    drive(mk(12'h4, 10'h0, 2'd0, 8'b1100_0111), 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R6 fetch no X");
    drive(mk(12'h4, 10'h0, 2'd0, 8'b1100_1111), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R6 access kind 3");
    // R7 megapage alignment
    drive(mk(12'h5, 10'h1, 2'd0, 8'b1100_0011), 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 level1 lo!=0");
    drive(mk(12'h5, 10'h0, 2'd0, 8'b1100_0011), 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 level1 aligned");
    drive(mk(12'h5, 10'h3FF, 2'd0, 8'b1100_0011), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 level0 lo ignored");
    // R8 software flag upkeep
    drive(mk(12'h6, 10'h0, 2'd0, 8'b1000_0011), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 A clear load");
    drive(mk(12'h6, 10'h0, 2'd0, 8'b0100_0111), 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 D clear store");
    drive(mk(12'h6, 10'h0, 2'd0, 8'b0100_0011), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 D clear load ok");
    // R9 hardware flag upkeep
    drive(mk(12'h7, 10'h0, 2'd0, 8'b0000_0011), 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 load sets A keeps D=0");
    drive(mk(12'h7, 10'h0, 2'd0, 8'b1000_0011), 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 load sets A keeps D=1");
    drive(mk(12'h7, 10'h0, 2'd0, 8'b0100_0111), 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 store sets D");
    drive(mk(12'h7, 10'h0, 2'd0, 8'b1100_0111), 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 flags set no upd");
    idle(1);
    // R10 priority between overlapping failures
    drive(mk(12'h8, 10'h1, 2'd0, 8'b0000_0101), 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R10 rsvenc over priv");
    drive(mk(12'h8, 10'h1, 2'd0, 8'b0000_1001), 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R10 priv over perm");
    drive(mk(12'h8, 10'h1, 2'd0, 8'b0000_1001), 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 perm over align");
    drive(mk(12'h8, 10'h1, 2'd0, 8'b0000_0011), 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 align over flags");
    // R11 G and software bits
    drive(mk(12'h9, 10'h2, 2'd3, 8'b1110_0111), 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 G+sw set");
    drive(mk(12'h9, 10'h2, 2'd0, 8'b1100_0111), 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 G+sw clear");
    drive(mk(12'h9, 10'h2, 2'd2, 8'b0110_0011), 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 G+sw upd path");
    idle(3);
    done = 1'b1;
    chk("R1 all results seen", 8'(sb.size()), 8'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule